// File: doc/BRIEF.md
# Floating-Point to Integer Converter with Selectable Overflow Semantics

This unit turns one binary64 operand, or a binary32 value held in binary64 layout, into a 64-bit integer register value. A 2-bit type code picks the target: signed 32, unsigned 32, signed 64 or unsigned 64. A 3-bit conversion mode chooses what happens to values that do not fit. Two mode pairs saturate, and they differ only in what a NaN becomes. The third pair wraps the value modulo the target width. One mode bit also forces truncation, whatever rounding mode is set.

Alongside the integer the unit produces a destination write-enable and a set of status bits: signaling-NaN invalid, conversion invalid, inexact, rounded-up and fraction-lost. It also produces an overflow indication, which is set whenever the integer does not represent the source exactly. When invalid-operation trapping is enabled and an invalid condition occurs, the write is suppressed. Each request presented with `in_valid` produces its outputs one clock later, held in a single register stage.

Top module: `f2i_convert`

## Requirements
- R1: Outputs appear exactly one cycle after a request; `out_valid` follows `in_valid` by one cycle, and with no request all outputs are zero, including after reset.
- R2: Rounding to integer uses `rnd_mode` 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity; `conv_mode` bit 2 set forces toward-zero regardless of `rnd_mode`.
- R3: `int_kind` 0 = signed 32, 1 = unsigned 32, 2 = signed 64, 3 = unsigned 64; a signed 32-bit result is sign-extended from bit 31 to 64 bits and an unsigned 32-bit result has bits 63:32 zero.
- R4: `conv_mode` 0 and 1 saturate: NaN gives the target minimum, a rounded value above the target maximum gives the maximum, and one below the minimum gives the minimum (s32 range 0xFFFFFFFF80000000..0x7FFFFFFF after extension, u32 0..0xFFFFFFFF, s64 and u64 their full ranges).
- R5: `conv_mode` 2 and 3 saturate the same way, except that NaN gives zero.
- R6: `conv_mode` 4 and 5 wrap: infinity, NaN or a magnitude of at least 2^128 gives zero; otherwise the rounded value taken as two's complement is cut to 64 bits and then to 32 bits for 32-bit targets, with the extension of R3.
- R7: `conv_mode` 6 and 7 are illegal: `mode_illegal` is 1, `wr_en` is 0, the result is zero and every status bit and overflow is zero.
- R8: `flag_inv_snan` is set only for a signaling NaN (exponent all ones, fraction non-zero, fraction MSB 0); `flag_inv_cvt` is set for any NaN and for any rounded value outside the target range, in every legal mode.
- R9: `flag_inexact` and `flag_frac_lost` are set when a legal, in-range conversion discards a non-zero fraction; `flag_rnd_up` is set when that rounding also increased the magnitude.
- R10: With `inv_trap_en` set and an invalid flag raised, `wr_en` is 0, the result is zero and `flag_rnd_up`/`flag_frac_lost` are 0, while the invalid flags are still reported.
- R11: `ovf_out` is 1 only when `ovf_en` is set, the conversion is written, and the source is NaN, out of range or not an exact integer; an exact conversion (including -0.0) gives 0.
- R12: With `src_single` set, the low 29 fraction bits of the operand are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_bits | input | 64 | Floating-point operand in binary64 layout |
| src_single | input | 1 | Operand is a binary32 value in binary64 layout |
| int_kind | input | 2 | Target integer type code |
| conv_mode | input | 3 | Conversion mode (rounding override and range semantics) |
| rnd_mode | input | 2 | Current rounding mode |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| ovf_en | input | 1 | Overflow reporting enable |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Integer result |
| wr_en | output | 1 | Destination write-enable |
| flag_inv_snan | output | 1 | Invalid: signaling NaN source |
| flag_inv_cvt | output | 1 | Invalid: NaN or out-of-range conversion |
| flag_inexact | output | 1 | Inexact result |
| flag_rnd_up | output | 1 | Magnitude was increased by rounding |
| flag_frac_lost | output | 1 | Fraction bits were discarded |
| ovf_out | output | 1 | Result does not represent the source exactly |
| mode_illegal | output | 1 | Conversion mode 6 or 7 was requested |

## Verification
The operand patterns are chosen so that each one separates two candidate behaviours. Ties such as 2.5 and 1.5 separate nearest-even from plain rounding. 123.75 in both signs separates ceiling, floor and truncation, and it also shows the forced-truncate bit overriding the rounding mode. Values just past each boundary are used: 2^31, 2^31+1, 2^32, 2^32+5, 2^63, 2^64 and 2^128, along with -0.25, -0.0 and the smallest denormal. Run through all three range semantics, these separate saturation from wrap-around, signed from unsigned extension, and a true negative from a value that only rounds to zero. Quiet and signaling NaNs, infinities, illegal modes, trap enable, overflow enable and the single-precision select are each applied on their own, so that every status bit is observed separately.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
    localparam int EXP_W       = 11;
    localparam int FRAC_W      = 52;
    localparam int MANT_W      = FRAC_W + 1;
    localparam int INT_W       = 64;
    localparam int HALF_W      = INT_W / 2;
    localparam int WIDE_W      = 2 * INT_W;
    localparam int BIAS        = (1 << (EXP_W - 1)) - 1;
    localparam int LSB_BIAS    = BIAS + FRAC_W;
    localparam int SINGLE_DROP = 29;
    localparam int HUGE_E      = WIDE_W - MANT_W + 1;
    localparam int SH_W        = $clog2(INT_W);

    typedef enum logic [1:0] {
        K_S32 = 2'd0,
        K_U32 = 2'd1,
        K_S64 = 2'd2,
        K_U64 = 2'd3
    } int_kind_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rnd_mode_e;

    // rounded magnitude and classification of the source
    typedef struct packed {
        logic              neg;
        logic              nan;
        logic              snan;
        logic              inf;
        logic              huge;
        logic [WIDE_W-1:0] mag;
        logic              lost;
        logic              bumped;
    } rnd_val_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             wr;
        logic             inv_snan;
        logic             inv_cvt;
        logic             inexact;
        logic             rnd_up;
        logic             frac_lost;
        logic             ovf;
        logic             illegal;
    } conv_out_t;

    function automatic logic [WIDE_W-1:0] pos_limit(input int_kind_e k);
        case (k)
            K_S32:   pos_limit = WIDE_W'({1'b0, {(HALF_W-1){1'b1}}});
            K_U32:   pos_limit = WIDE_W'({HALF_W{1'b1}});
            K_S64:   pos_limit = WIDE_W'({1'b0, {(INT_W-1){1'b1}}});
            default: pos_limit = WIDE_W'({INT_W{1'b1}});
        endcase
    endfunction

    function automatic logic [WIDE_W-1:0] neg_limit(input int_kind_e k);
        case (k)
            K_S32:   neg_limit = WIDE_W'(1) << (HALF_W - 1);
            K_S64:   neg_limit = WIDE_W'(1) << (INT_W - 1);
            default: neg_limit = '0;
        endcase
    endfunction

    function automatic logic [INT_W-1:0] fit_kind(input int_kind_e k, input logic [INT_W-1:0] v);
        case (k)
            K_S32:   fit_kind = {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
            K_U32:   fit_kind = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
            default: fit_kind = v;
        endcase
    endfunction

    function automatic logic [INT_W-1:0] kind_max(input int_kind_e k);
        kind_max = pos_limit(k)[INT_W-1:0];
    endfunction

    function automatic logic [INT_W-1:0] kind_min(input int_kind_e k);
        kind_min = fit_kind(k, ~neg_limit(k)[INT_W-1:0] + INT_W'(1));
    endfunction
endpackage

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
    import f2i_pkg::*;
(
    input  logic [INT_W-1:0] src_bits,
    input  logic             src_single,
    input  logic             force_trunc,
    input  rnd_mode_e        rmode,
    output rnd_val_t         rv
);
    logic             sgn, all1, guard, sticky, inc;
    logic [EXP_W-1:0] ex, ue;
    logic [FRAC_W-1:0] fr;
    logic [MANT_W-1:0] mant;
    logic [INT_W-1:0] m64, ipart, lowmask;
    logic [SH_W-1:0]  rs;
    int               e_rel;

    always_comb begin
        sgn  = src_bits[INT_W-1];
        ex   = src_bits[INT_W-2 -: EXP_W];
        fr   = src_bits[FRAC_W-1:0];
        if (src_single) fr[SINGLE_DROP-1:0] = '0;
        all1 = &ex;
        ue   = (ex == '0) ? EXP_W'(1) : ex;
        mant = {|ex, fr};
        m64  = INT_W'(mant);
        e_rel = int'(ue) - LSB_BIAS;

        rv         = '0;
        rv.neg     = sgn;
        rv.nan     = all1 & (|fr);
        rv.snan    = all1 & (|fr) & ~fr[FRAC_W-1];
        rv.inf     = all1 & ~(|fr);
        ipart      = '0;
        lowmask    = '0;
        rs         = '0;
        guard      = 1'b0;
        sticky     = 1'b0;
        inc        = 1'b0;

        if (e_rel >= 0) begin
            // integer already, possibly very large
            if (!all1) begin
                if (e_rel >= HUGE_E) rv.huge = 1'b1;
                else                 rv.mag  = WIDE_W'(mant) << e_rel[6:0];
            end
        end else begin
            rs      = (e_rel < -(INT_W - 1)) ? SH_W'(INT_W - 1) : SH_W'(-e_rel);
            ipart   = m64 >> rs;
            guard   = m64[rs - SH_W'(1)];
            lowmask = (INT_W'(1) << (rs - SH_W'(1))) - INT_W'(1);
            sticky  = |(m64 & lowmask);
            if (!force_trunc) begin
                case (rmode)
                    RM_NEAR: inc = guard & (sticky | ipart[0]);
                    RM_UP:   inc = ~sgn & (guard | sticky);
                    RM_DOWN: inc = sgn & (guard | sticky);
                    default: inc = 1'b0;
                endcase
            end
            rv.mag    = WIDE_W'(ipart + INT_W'(inc));
            rv.lost   = guard | sticky;
            rv.bumped = inc;
        end
    end
endmodule

// File: rtl/f2i_range.sv
`timescale 1ns/1ps
module f2i_range
    import f2i_pkg::*;
(
    input  rnd_val_t  rv,
    input  int_kind_e kind,
    output logic      above,
    output logic      below
);
    logic big, neg_eff;

    always_comb begin
        big     = rv.huge | rv.inf;
        neg_eff = rv.neg & (big | (|rv.mag));
        above   = ~rv.nan & ~neg_eff & (big | (rv.mag > pos_limit(kind)));
        below   = ~rv.nan &  neg_eff & (big | (rv.mag > neg_limit(kind)));
    end
endmodule

// File: rtl/f2i_select.sv
`timescale 1ns/1ps
module f2i_select
    import f2i_pkg::*;
(
    input  rnd_val_t   rv,
    input  logic       above,
    input  logic       below,
    input  int_kind_e  kind,
    input  logic [2:0] mode,
    input  logic       inv_trap_en,
    input  logic       ovf_en,
    output conv_out_t  co
);
    logic             legal, inv_cvt, trap, kept_lost;
    logic [INT_W-1:0] tc, wrapped, pick;

    always_comb begin
        legal   = ~(mode[2] & mode[1]);
        tc      = rv.neg ? (~rv.mag[INT_W-1:0] + INT_W'(1)) : rv.mag[INT_W-1:0];
        wrapped = fit_kind(kind, tc);

        case (mode[2:1])
            2'b00: begin
                if      (rv.nan) pick = kind_min(kind);
                else if (above)  pick = kind_max(kind);
                else if (below)  pick = kind_min(kind);
                else             pick = wrapped;
            end
            2'b01: begin
                if      (rv.nan) pick = '0;
                else if (above)  pick = kind_max(kind);
                else if (below)  pick = kind_min(kind);
                else             pick = wrapped;
            end
            2'b10: begin
                if (rv.nan | rv.inf | rv.huge) pick = '0;
                else                           pick = wrapped;
            end
            default: pick = '0;
        endcase

        inv_cvt   = rv.nan | above | below;
        trap      = inv_trap_en & (inv_cvt | rv.snan);
        kept_lost = rv.lost & ~inv_cvt & ~trap;

        co = '0;
        if (legal) begin
            co.wr        = ~trap;
            co.value     = trap ? '0 : pick;
            co.inv_snan  = rv.snan;
            co.inv_cvt   = inv_cvt;
            co.inexact   = kept_lost;
            co.frac_lost = kept_lost;
            co.rnd_up    = kept_lost & rv.bumped;
            co.ovf       = ovf_en & ~trap & (inv_cvt | rv.lost);
        end else begin
            co.illegal = 1'b1;
        end
    end
endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
module f2i_convert
    import f2i_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] src_bits,
    input  logic        src_single,
    input  logic [1:0]  int_kind,
    input  logic [2:0]  conv_mode,
    input  logic [1:0]  rnd_mode,
    input  logic        inv_trap_en,
    input  logic        ovf_en,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        wr_en,
    output logic        flag_inv_snan,
    output logic        flag_inv_cvt,
    output logic        flag_inexact,
    output logic        flag_rnd_up,
    output logic        flag_frac_lost,
    output logic        ovf_out,
    output logic        mode_illegal
);
    rnd_val_t  rv;
    logic      above, below;
    conv_out_t co, q;
    logic      v_q;

    f2i_round u_round (
        .src_bits   (src_bits),
        .src_single (src_single),
        .force_trunc(conv_mode[2]),
        .rmode      (rnd_mode_e'(rnd_mode)),
        .rv         (rv)
    );

    f2i_range u_range (
        .rv   (rv),
        .kind (int_kind_e'(int_kind)),
        .above(above),
        .below(below)
    );

    f2i_select u_select (
        .rv         (rv),
        .above      (above),
        .below      (below),
        .kind       (int_kind_e'(int_kind)),
        .mode       (conv_mode),
        .inv_trap_en(inv_trap_en),
        .ovf_en     (ovf_en),
        .co         (co)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            q   <= '0;
        end else begin
            v_q <= in_valid;
            q   <= in_valid ? co : '0;
        end
    end

    assign out_valid      = v_q;
    assign result         = q.value;
    assign wr_en          = q.wr;
    assign flag_inv_snan  = q.inv_snan;
    assign flag_inv_cvt   = q.inv_cvt;
    assign flag_inexact   = q.inexact;
    assign flag_rnd_up    = q.rnd_up;
    assign flag_frac_lost = q.frac_lost;
    assign ovf_out        = q.ovf;
    assign mode_illegal   = q.illegal;
endmodule

// File: rtl/f2i_convert_chk.sv
`timescale 1ns/1ps
module f2i_convert_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] src_bits,
    input logic        src_single,
    input logic [1:0]  int_kind,
    input logic [2:0]  conv_mode,
    input logic [1:0]  rnd_mode,
    input logic        inv_trap_en,
    input logic        ovf_en,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        wr_en,
    input logic        flag_inv_snan,
    input logic        flag_inv_cvt,
    input logic        flag_inexact,
    input logic        flag_rnd_up,
    input logic        flag_frac_lost,
    input logic        ovf_out,
    input logic        mode_illegal
);
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && result == 64'd0));
    p_u32_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int_kind == 2'd1) |=> (result[63:32] == 32'd0));
    p_s32_ext_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int_kind == 2'd0) |=> (result[63:31] == '0 || result[63:31] == '1));
    p_illegal_r7: assert property (@(posedge clk) disable iff (rst)
        mode_illegal |-> (!wr_en && !flag_inv_snan && !flag_inv_cvt && !flag_inexact && !ovf_out));
    p_illegal_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && conv_mode[2] && conv_mode[1]) |=> mode_illegal);
    p_snan_cvt_r8: assert property (@(posedge clk) disable iff (rst)
        flag_inv_snan |-> flag_inv_cvt);
    p_rnd_up_r9: assert property (@(posedge clk) disable iff (rst)
        flag_rnd_up |-> (flag_inexact && flag_frac_lost && !flag_inv_cvt));
    p_trap_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && inv_trap_en) |=> !((flag_inv_cvt || flag_inv_snan) && wr_en));
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ovf_en) |=> !ovf_out);
    p_ovf_written_r11: assert property (@(posedge clk) disable iff (rst)
        ovf_out |-> wr_en);
endmodule

bind f2i_convert f2i_convert_chk u_chk (.*);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src_bits;
    logic        src_single;
    logic [1:0]  int_kind;
    logic [2:0]  conv_mode;
    logic [1:0]  rnd_mode;
    logic        inv_trap_en;
    logic        ovf_en;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_en, flag_inv_snan, flag_inv_cvt, flag_inexact;
    logic        flag_rnd_up, flag_frac_lost, ovf_out, mode_illegal;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    // flag order: wr snan cvt inexact rnd_up frac_lost ovf illegal
    localparam logic [7:0] F_EXACT = 8'b1000_0000;
    localparam logic [7:0] F_LOST  = 8'b1001_0110;
    localparam logic [7:0] F_UP    = 8'b1001_1110;
    localparam logic [7:0] F_INV   = 8'b1010_0010;
    localparam logic [7:0] F_SNAN  = 8'b1110_0010;
    localparam logic [7:0] F_ILL   = 8'b0000_0001;

    localparam logic [63:0] D_1P5   = 64'h3FF8_0000_0000_0000;
    localparam logic [63:0] D_QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] D_NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] D_M1    = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_P2_32 = 64'h41F0_0000_0000_0000;

    always #4 clk = ~clk;

    f2i_convert u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_bits(src_bits),
        .src_single(src_single), .int_kind(int_kind), .conv_mode(conv_mode),
        .rnd_mode(rnd_mode), .inv_trap_en(inv_trap_en), .ovf_en(ovf_en),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .flag_inv_snan(flag_inv_snan), .flag_inv_cvt(flag_inv_cvt),
        .flag_inexact(flag_inexact), .flag_rnd_up(flag_rnd_up),
        .flag_frac_lost(flag_frac_lost), .ovf_out(ovf_out),
        .mode_illegal(mode_illegal)
    );

    function automatic logic [7:0] act_flags();
        return {wr_en, flag_inv_snan, flag_inv_cvt, flag_inexact,
                flag_rnd_up, flag_frac_lost, ovf_out, mode_illegal};
    endfunction

    task automatic check(input string tag, input logic [63:0] ev, input logic [7:0] ef);
        nchk += 2;
        if (result !== ev) begin
            nfail++;
            $display("FAIL %s result: actual %h expected %h", tag, result, ev);
        end
        if (act_flags() !== ef) begin
            nfail++;
            $display("FAIL %s flags: actual %b expected %b", tag, act_flags(), ef);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic conv(input logic [63:0] op, input logic [1:0] k, input logic [2:0] m,
                        input logic [1:0] rm, input logic sgl, input logic inv, input logic oe);
        @(negedge clk);
        src_bits = op; int_kind = k; conv_mode = m; rnd_mode = rm;
        src_single = sgl; inv_trap_en = inv; ovf_en = oe; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check_bit("R1 reset out_valid", out_valid, 1'b0);
        check("R1 reset", 64'd0, 8'd0);
    endtask

    task automatic t_latency;
        conv(64'h4008_0000_0000_0000, 2'd2, 3'd0, 2'd0, 0, 0, 1);
        check_bit("R1 out_valid one cycle after request", out_valid, 1'b1);
        check("R1 value 3.0", 64'd3, F_EXACT);
        @(negedge clk);
        check_bit("R1 out_valid drops", out_valid, 1'b0);
        check("R1 idle outputs", 64'd0, 8'd0);
    endtask

    task automatic t_round;
        conv(64'h4004_0000_0000_0000, 2'd2, 3'd0, 2'd0, 0, 0, 1); check("R2 2.5 nearest-even", 64'd2, F_LOST);
        conv(D_1P5, 2'd2, 3'd0, 2'd0, 0, 0, 1);                   check("R2 1.5 nearest-even", 64'd2, F_UP);
        conv(64'hC004_0000_0000_0000, 2'd2, 3'd0, 2'd0, 0, 0, 1); check("R2 -2.5 nearest-even", 64'hFFFF_FFFF_FFFF_FFFE, F_LOST);
        conv(64'h405E_F000_0000_0000, 2'd2, 3'd0, 2'd0, 0, 0, 1); check("R2 123.75 near", 64'd124, F_UP);
        conv(64'h405E_F000_0000_0000, 2'd2, 3'd0, 2'd1, 0, 0, 1); check("R2 123.75 trunc", 64'd123, F_LOST);
        conv(64'h405E_F000_0000_0000, 2'd2, 3'd0, 2'd2, 0, 0, 1); check("R2 123.75 ceil", 64'd124, F_UP);
        conv(64'h405E_F000_0000_0000, 2'd2, 3'd0, 2'd3, 0, 0, 1); check("R2 123.75 floor", 64'd123, F_LOST);
        conv(64'hC05E_F000_0000_0000, 2'd2, 3'd0, 2'd3, 0, 0, 1); check("R2 -123.75 floor", 64'hFFFF_FFFF_FFFF_FF84, F_UP);
        conv(64'hC05E_F000_0000_0000, 2'd2, 3'd1, 2'd2, 0, 0, 1); check("R2 -123.75 ceil", 64'hFFFF_FFFF_FFFF_FF85, F_LOST);
        conv(D_1P5, 2'd2, 3'd4, 2'd0, 0, 0, 1);                   check("R2 forced trunc mode bit 2", 64'd1, F_LOST);
    endtask

    task automatic t_types;
        conv(D_M1, 2'd0, 3'd0, 2'd0, 0, 0, 1);                    check("R3 -1 s32 sign-extended", 64'hFFFF_FFFF_FFFF_FFFF, F_EXACT);
        conv(64'h4008_0000_0000_0000, 2'd1, 3'd0, 2'd0, 0, 0, 1); check("R3 3.0 u32", 64'd3, F_EXACT);
        conv(D_M1, 2'd2, 3'd0, 2'd0, 0, 0, 1);                    check("R3 -1 s64", 64'hFFFF_FFFF_FFFF_FFFF, F_EXACT);
    endtask

    task automatic t_sat_min;
        conv(D_QNAN, 2'd0, 3'd0, 2'd0, 0, 0, 1);                  check("R4 NaN s32 to min", 64'hFFFF_FFFF_8000_0000, F_INV);
        conv(D_P2_32, 2'd1, 3'd1, 2'd0, 0, 0, 1);                 check("R4 2^32 u32 to max", 64'h0000_0000_FFFF_FFFF, F_INV);
        conv(D_M1, 2'd3, 3'd0, 2'd0, 0, 0, 1);                    check("R4 -1 u64 to min", 64'd0, F_INV);
        conv(D_NINF, 2'd2, 3'd1, 2'd0, 0, 0, 1);                  check("R4 -inf s64 to min", 64'h8000_0000_0000_0000, F_INV);
        conv(64'h41E0_0000_0000_0000, 2'd0, 3'd0, 2'd0, 0, 0, 1); check("R4 2^31 s32 to max", 64'h0000_0000_7FFF_FFFF, F_INV);
    endtask

    task automatic t_sat_zero;
        conv(D_QNAN, 2'd2, 3'd2, 2'd0, 0, 0, 1);                  check("R5 NaN s64 to zero", 64'd0, F_INV);
        conv(64'h43E0_0000_0000_0000, 2'd2, 3'd3, 2'd0, 0, 0, 1); check("R5 2^63 s64 to max", 64'h7FFF_FFFF_FFFF_FFFF, F_INV);
        conv(64'h43F0_0000_0000_0000, 2'd3, 3'd2, 2'd0, 0, 0, 1); check("R5 2^64 u64 to max", 64'hFFFF_FFFF_FFFF_FFFF, F_INV);
        conv(64'hC1E0_0000_0000_0000, 2'd0, 3'd3, 2'd0, 0, 0, 1); check("R5 -2^31 s32 in range", 64'hFFFF_FFFF_8000_0000, F_EXACT);
        conv(D_NINF, 2'd1, 3'd2, 2'd0, 0, 0, 1);                  check("R5 -inf u32 to min", 64'd0, F_INV);
    endtask

    task automatic t_modular;
        conv(D_PINF, 2'd3, 3'd4, 2'd0, 0, 0, 1);                  check("R6 inf wraps to zero", 64'd0, F_INV);
        conv(D_QNAN, 2'd0, 3'd5, 2'd0, 0, 0, 1);                  check("R6 NaN wraps to zero", 64'd0, F_INV);
        conv(64'h41F0_0000_0050_0000, 2'd1, 3'd4, 2'd0, 0, 0, 1); check("R6 2^32+5 u32", 64'd5, F_INV);
        conv(64'hC1F0_0000_0050_0000, 2'd0, 3'd5, 2'd0, 0, 0, 1); check("R6 -(2^32+5) s32", 64'hFFFF_FFFF_FFFF_FFFB, F_INV);
        conv(64'h41E0_0000_0020_0000, 2'd0, 3'd4, 2'd0, 0, 0, 1); check("R6 2^31+1 s32", 64'hFFFF_FFFF_8000_0001, F_INV);
        conv(64'h47F0_0000_0000_0000, 2'd2, 3'd4, 2'd0, 0, 0, 1); check("R6 2^128 to zero", 64'd0, F_INV);
        conv(64'h405E_F000_0000_0000, 2'd0, 3'd4, 2'd2, 0, 0, 1); check("R6 123.75 in range", 64'd123, F_LOST);
    endtask

    task automatic t_illegal;
        conv(D_SNAN, 2'd2, 3'd6, 2'd0, 0, 0, 1); check("R7 mode 6 illegal", 64'd0, F_ILL);
        conv(D_1P5, 2'd0, 3'd7, 2'd2, 0, 0, 1);  check("R7 mode 7 illegal", 64'd0, F_ILL);
    endtask

    task automatic t_invalid;
        conv(D_SNAN, 2'd2, 3'd0, 2'd0, 0, 0, 1); check("R8 sNaN saturating", 64'h8000_0000_0000_0000, F_SNAN);
        conv(D_SNAN, 2'd2, 3'd2, 2'd0, 0, 0, 1); check("R8 sNaN nan-to-zero", 64'd0, F_SNAN);
        conv(D_QNAN, 2'd3, 3'd3, 2'd0, 0, 0, 1); check("R8 qNaN no snan flag", 64'd0, F_INV);
    endtask

    task automatic t_inexact;
        conv(64'h0000_0000_0000_0001, 2'd2, 3'd0, 2'd2, 0, 0, 1); check("R9 denormal ceil", 64'd1, F_UP);
        conv(64'h0000_0000_0000_0001, 2'd2, 3'd0, 2'd3, 0, 0, 1); check("R9 denormal floor", 64'd0, F_LOST);
        conv(64'hBFD0_0000_0000_0000, 2'd1, 3'd0, 2'd1, 0, 0, 1); check("R9 -0.25 u32 trunc", 64'd0, F_LOST);
    endtask

    task automatic t_trap;
        conv(D_P2_32, 2'd1, 3'd0, 2'd0, 0, 1, 1); check("R10 trap out of range", 64'd0, 8'b0010_0000);
        conv(D_SNAN, 2'd0, 3'd0, 2'd0, 0, 1, 1);  check("R10 trap sNaN", 64'd0, 8'b0110_0000);
        conv(D_1P5, 2'd2, 3'd0, 2'd0, 0, 1, 1);   check("R10 no trap when valid", 64'd2, F_UP);
    endtask

    task automatic t_overflow;
        conv(D_1P5, 2'd2, 3'd0, 2'd0, 0, 0, 0);                   check("R11 ovf disabled", 64'd2, 8'b1001_1100);
        conv(64'h8000_0000_0000_0000, 2'd2, 3'd0, 2'd0, 0, 0, 1); check("R11 -0.0 s64 exact", 64'd0, F_EXACT);
        conv(64'h8000_0000_0000_0000, 2'd1, 3'd2, 2'd0, 0, 0, 1); check("R11 -0.0 u32 exact", 64'd0, F_EXACT);
        conv(D_QNAN, 2'd2, 3'd0, 2'd0, 0, 0, 0);                  check("R11 NaN ovf disabled", 64'h8000_0000_0000_0000, 8'b1010_0000);
    endtask

    task automatic t_single;
        conv(64'h3FF0_0000_0000_1000, 2'd2, 3'd0, 2'd2, 1, 0, 1); check("R12 single drops low bits", 64'd1, F_EXACT);
        conv(64'h3FF0_0000_0000_1000, 2'd2, 3'd0, 2'd2, 0, 0, 1); check("R12 double keeps low bits", 64'd2, F_UP);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; src_bits = '0; src_single = 1'b0;
        int_kind = '0; conv_mode = '0; rnd_mode = '0; inv_trap_en = 1'b0; ovf_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_round();
        t_types();
        t_sat_min();
        t_sat_zero();
        t_modular();
        t_illegal();
        t_invalid();
        t_inexact();
        t_trap();
        t_overflow();
        t_single();
        done = 1;
        summary();
        $finish;
    end
endmodule